// File: doc/BRIEF.md
# Mode-Switching Branch Unit

This unit executes two register-to-register branch operations that also change the addressing mode. The call form saves the current status word as link information in a register, then optionally branches. The return form copies the current mode bit into one register, then optionally branches. The branch target and the new mode both come from a second register.

Register field value 0 means "no operand" for the branch source. For the return form it also means "no operand" for the mode insert. The next status word is built from the register contents read in the issue cycle, before any write that the same operation makes. This keeps the result correct when both fields name the same register.

All results are registered. They appear one clock after an issue cycle, together with a register-file write request that carries a per-bit merge mask. The issue stage owns the register file. It must commit the write with the mask, so that bits whose mask bit is 0 keep their old value.

Top module: `modesw_branch_unit`

## Requirements
- R1: A call (`issue_op`=0) writes the link word to register `fld_a`, including register 0. The link word has the current mode bit in bit 31 and the current sequential address in bits 30:0. The write uses an all-ones mask.
- R2: When `fld_b` is 0, no branch occurs. `branch_taken` is 0, and the next status word repeats the current mode and the current address.
- R3: When `fld_b` is nonzero, `branch_taken` is 1 and the new mode equals bit 31 of register `fld_b`.
- R4: With a new mode of 1 (31-bit), the next address is bits 30:0 of register `fld_b`.
- R5: With a new mode of 0 (24-bit), the next address is bits 23:0 of register `fld_b`, and bits 30:24 are forced to 0.
- R6: When `fld_a` equals `fld_b` on a call, the next status word comes from the register value before the link write.
- R7: A return (`issue_op`=1) with nonzero `fld_a` writes register `fld_a` with mask bit 31 only. Bit 31 of the write data is the current mode bit.
- R8: A return with `fld_a` 0 makes no register write.
- R9: `trace_evt` pulses only for a call with nonzero `fld_b`. A return never raises it.
- R10: Results appear exactly one cycle after an issue cycle. In any other cycle, and during reset, `out_valid`, `rf_we` and `trace_evt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | An operation is issued this cycle |
| issue_op | input | 1 | 0 = call form, 1 = return form |
| fld_a | input | 4 | Register field for link or mode insert |
| fld_b | input | 4 | Register field for branch source, 0 = none |
| rf_raddr | output | 4 | Register file read address (follows `fld_b`) |
| rf_rdata | input | 32 | Register file read data, same cycle |
| psw_mode | input | 1 | Current addressing mode (1 = 31-bit) |
| psw_addr | input | 31 | Current sequential instruction address |
| out_valid | output | 1 | Results below are valid |
| npsw_mode | output | 1 | Next addressing mode |
| npsw_addr | output | 31 | Next instruction address |
| branch_taken | output | 1 | The operation branched |
| rf_we | output | 1 | Register write request |
| rf_widx | output | 4 | Register write index |
| rf_wdata | output | 32 | Register write data |
| rf_wmask | output | 32 | Per-bit write mask |
| trace_evt | output | 1 | Trace event strobe |

## Verification
The assertions assume that `psw_mode`, `psw_addr` and the operation fields hold steady for the whole issue cycle. They also assume that `rf_rdata` returns register `fld_b` in that same cycle, with no bypass of a write still in flight. The bench meets these assumptions in three ways. It drives every input on the falling edge. It serves reads from its own register array, which it never updates from the unit's writes. It inserts an idle cycle after each issue, so the outputs of one operation never overlap the next.

// File: rtl/mswb_pkg.sv
package mswb_pkg;
  typedef enum logic {
    OP_CALL = 1'b0,
    OP_RET  = 1'b1
  } mswb_op_e;
endpackage

// File: rtl/mswb_target_gen.sv
module mswb_target_gen #(
  parameter int XLEN   = 32,
  parameter int NARROW = 24
) (
  input  logic [XLEN-1:0] src,
  output logic            new_mode,
  output logic [XLEN-2:0] new_addr
);
  localparam int AW   = XLEN - 1;
  localparam int PADW = AW - NARROW;

  logic [AW-1:0] narrow_addr;

  generate
    if (PADW > 0) begin : g_pad
      assign narrow_addr = {{PADW{1'b0}}, src[NARROW-1:0]};
    end else begin : g_nopad
      assign narrow_addr = src[AW-1:0];
    end
  endgenerate

  // Mode bit of the source selects how the target is formed.
  assign new_mode = src[XLEN-1];
  assign new_addr = new_mode ? src[AW-1:0] : narrow_addr;
endmodule

// File: rtl/mswb_wr_gen.sv
module mswb_wr_gen
  import mswb_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IDXW = 4
) (
  input  mswb_op_e        op,
  input  logic [IDXW-1:0] fld_a,
  input  logic            cur_mode,
  input  logic [XLEN-2:0] cur_addr,
  output logic            we,
  output logic [IDXW-1:0] idx,
  output logic [XLEN-1:0] data,
  output logic [XLEN-1:0] mask
);
  localparam logic [XLEN-1:0] TOP_ONLY = {1'b1, {(XLEN-1){1'b0}}};

  always_comb begin
    idx = fld_a;
    if (op == OP_CALL) begin
      we   = 1'b1;
      data = {cur_mode, cur_addr};
      mask = '1;
    end else begin
      we   = (fld_a != '0);
      data = {cur_mode, {(XLEN-1){1'b0}}};
      mask = TOP_ONLY;
    end
  end
endmodule

// File: rtl/modesw_branch_unit.sv
module modesw_branch_unit
  import mswb_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NREG   = 16,
  parameter int NARROW = 24
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    issue_valid,
  input  logic                    issue_op,
  input  logic [$clog2(NREG)-1:0] fld_a,
  input  logic [$clog2(NREG)-1:0] fld_b,
  output logic [$clog2(NREG)-1:0] rf_raddr,
  input  logic [XLEN-1:0]         rf_rdata,
  input  logic                    psw_mode,
  input  logic [XLEN-2:0]         psw_addr,
  output logic                    out_valid,
  output logic                    npsw_mode,
  output logic [XLEN-2:0]         npsw_addr,
  output logic                    branch_taken,
  output logic                    rf_we,
  output logic [$clog2(NREG)-1:0] rf_widx,
  output logic [XLEN-1:0]         rf_wdata,
  output logic [XLEN-1:0]         rf_wmask,
  output logic                    trace_evt
);
  localparam int IDXW = $clog2(NREG);
  localparam int AW   = XLEN - 1;

  mswb_op_e        op;
  logic            do_branch;
  logic            tgt_mode;
  logic [AW-1:0]   tgt_addr;
  logic            nx_mode;
  logic [AW-1:0]   nx_addr;
  logic            w_en;
  logic [IDXW-1:0] w_idx;
  logic [XLEN-1:0] w_data;
  logic [XLEN-1:0] w_mask;

  assign op        = mswb_op_e'(issue_op);
  assign rf_raddr  = fld_b;
  assign do_branch = (fld_b != '0);

  mswb_target_gen #(.XLEN(XLEN), .NARROW(NARROW)) u_tgt (
    .src      (rf_rdata),
    .new_mode (tgt_mode),
    .new_addr (tgt_addr)
  );

  mswb_wr_gen #(.XLEN(XLEN), .IDXW(IDXW)) u_wr (
    .op       (op),
    .fld_a    (fld_a),
    .cur_mode (psw_mode),
    .cur_addr (psw_addr),
    .we       (w_en),
    .idx      (w_idx),
    .data     (w_data),
    .mask     (w_mask)
  );

  // The next status word uses the value read this cycle, ahead of the link write.
  always_comb begin
    if (do_branch) begin
      nx_mode = tgt_mode;
      nx_addr = tgt_addr;
    end else begin
      nx_mode = psw_mode;
      nx_addr = psw_addr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      npsw_mode    <= 1'b0;
      npsw_addr    <= '0;
      branch_taken <= 1'b0;
      rf_we        <= 1'b0;
      rf_widx      <= '0;
      rf_wdata     <= '0;
      rf_wmask     <= '0;
      trace_evt    <= 1'b0;
    end else begin
      out_valid    <= issue_valid;
      npsw_mode    <= nx_mode;
      npsw_addr    <= nx_addr;
      branch_taken <= issue_valid && do_branch;
      rf_we        <= issue_valid && w_en;
      rf_widx      <= w_idx;
      rf_wdata     <= w_data;
      rf_wmask     <= w_mask;
      trace_evt    <= issue_valid && (op == OP_CALL) && do_branch;
    end
  end

  AST_NOBR_KEEPS_PSW: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && fld_b == '0) |=> (!branch_taken && npsw_mode == $past(psw_mode)
                                      && npsw_addr == $past(psw_addr))); // R2
  AST_NARROW_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && branch_taken && !npsw_mode) |-> (npsw_addr >> NARROW) == '0); // R5
  AST_MODE_FROM_SRC: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && fld_b != '0) |=> (npsw_mode == $past(rf_rdata[XLEN-1]))); // R3
  AST_RET_NO_TRACE: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && issue_op) |=> !trace_evt); // R9
  AST_TRACE_HAS_BRANCH: assert property (@(posedge clk) disable iff (rst)
    trace_evt |-> (out_valid && branch_taken)); // R9
  AST_INSERT_NOT_R0: assert property (@(posedge clk) disable iff (rst)
    (rf_we && $countones(rf_wmask) == 1) |-> (rf_widx != '0 && rf_wmask[XLEN-1])); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !issue_valid |=> (!out_valid && !rf_we && !trace_evt)); // R10
endmodule

// File: tb/modesw_branch_unit_tb.sv
module modesw_branch_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        issue_valid = 1'b0;
  logic        issue_op = 1'b0;
  logic [3:0]  fld_a = '0;
  logic [3:0]  fld_b = '0;
  logic [3:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic        psw_mode = 1'b0;
  logic [30:0] psw_addr = '0;
  logic        out_valid, npsw_mode, branch_taken, rf_we, trace_evt;
  logic [30:0] npsw_addr;
  logic [3:0]  rf_widx;
  logic [31:0] rf_wdata, rf_wmask;

  logic [31:0] regs [16];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  assign rf_rdata = regs[rf_raddr];

  modesw_branch_unit u_dut (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
    .fld_a(fld_a), .fld_b(fld_b), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .psw_mode(psw_mode), .psw_addr(psw_addr), .out_valid(out_valid),
    .npsw_mode(npsw_mode), .npsw_addr(npsw_addr), .branch_taken(branch_taken),
    .rf_we(rf_we), .rf_widx(rf_widx), .rf_wdata(rf_wdata), .rf_wmask(rf_wmask),
    .trace_evt(trace_evt)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [30:0] exp_tgt(input logic [31:0] v);
    return v[31] ? v[30:0] : {7'd0, v[23:0]};
  endfunction

  // Drive on the falling edge; results are sampled one full clock later.
  task automatic issue(input logic op, input logic [3:0] a, input logic [3:0] b,
                       input logic m, input logic [30:0] ad);
    @(negedge clk);
    issue_valid = 1'b1; issue_op = op; fld_a = a; fld_b = b; psw_mode = m; psw_addr = ad;
    @(negedge clk);
    issue_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(!out_valid && !rf_we && !trace_evt, "R10 reset", {29'd0, out_valid, rf_we, trace_evt}, 32'd0);
  endtask

  task automatic t_call_nobranch();
    issue(1'b0, 4'd3, 4'd0, 1'b1, 31'h1234_5678);
    chk(out_valid && !branch_taken, "R2 no branch", {30'd0, out_valid, branch_taken}, 32'd2);
    chk(npsw_mode == 1'b1 && npsw_addr == 31'h1234_5678, "R2 psw kept", {npsw_mode, npsw_addr}, 32'h9234_5678);
    chk(rf_we && rf_widx == 4'd3 && rf_wmask == 32'hFFFF_FFFF, "R1 link write", {rf_we, 27'd0, rf_widx}, 32'h8000_0003);
    chk(rf_wdata == 32'h9234_5678, "R1 link data", rf_wdata, 32'h9234_5678);
    chk(!trace_evt, "R9 no trace without branch", {31'd0, trace_evt}, 32'd0);
  endtask

  task automatic t_call_r0_link();
    issue(1'b0, 4'd0, 4'd0, 1'b0, 31'h0000_0ABC);
    chk(rf_we && rf_widx == 4'd0 && rf_wdata == 32'h0000_0ABC, "R1 link into reg 0", rf_wdata, 32'h0000_0ABC);
  endtask

  task automatic t_call_branch31();
    issue(1'b0, 4'd2, 4'd5, 1'b0, 31'h0000_1000);
    chk(branch_taken && npsw_mode == 1'b1, "R3 mode from src", {31'd0, npsw_mode}, 32'd1);
    chk(npsw_addr == exp_tgt(regs[5]), "R4 wide target", {1'b0, npsw_addr}, {1'b0, exp_tgt(regs[5])});
    chk(trace_evt, "R9 call trace", {31'd0, trace_evt}, 32'd1);
    chk(rf_wdata == 32'h0000_1000, "R1 link old mode", rf_wdata, 32'h0000_1000);
  endtask

  task automatic t_call_branch24();
    issue(1'b0, 4'd2, 4'd6, 1'b1, 31'h0000_2000);
    chk(npsw_mode == 1'b0, "R3 narrow mode", {31'd0, npsw_mode}, 32'd0);
    chk(npsw_addr == 31'h0056_789A, "R5 narrow target", {1'b0, npsw_addr}, 32'h0056_789A);
  endtask

  task automatic t_call_same_reg();
    issue(1'b0, 4'd7, 4'd7, 1'b1, 31'h0000_3000);
    chk(npsw_addr == exp_tgt(regs[7]) && npsw_mode == regs[7][31], "R6 old value used",
        {npsw_mode, npsw_addr}, {regs[7][31], exp_tgt(regs[7])});
    chk(rf_widx == 4'd7 && rf_wdata == 32'h8000_3000, "R6 link still written", rf_wdata, 32'h8000_3000);
  endtask

  task automatic t_ret_basic();
    issue(1'b1, 4'd4, 4'd5, 1'b1, 31'h0000_4000);
    chk(rf_we && rf_widx == 4'd4 && rf_wmask == 32'h8000_0000, "R7 insert mask", rf_wmask, 32'h8000_0000);
    chk(rf_wdata[31] == 1'b1, "R7 insert value", {31'd0, rf_wdata[31]}, 32'd1);
    chk(!trace_evt && branch_taken, "R9 return no trace", {30'd0, trace_evt, branch_taken}, 32'd1);
    chk(npsw_addr == exp_tgt(regs[5]), "R4 return target", {1'b0, npsw_addr}, {1'b0, exp_tgt(regs[5])});
  endtask

  task automatic t_ret_zero_a();
    issue(1'b1, 4'd0, 4'd6, 1'b0, 31'h0000_5000);
    chk(!rf_we, "R8 no write for reg 0", {31'd0, rf_we}, 32'd0);
    chk(npsw_addr == 31'h0056_789A, "R5 return narrow", {1'b0, npsw_addr}, 32'h0056_789A);
  endtask

  task automatic t_ret_nobranch();
    issue(1'b1, 4'd9, 4'd0, 1'b0, 31'h0000_6000);
    chk(!branch_taken && npsw_addr == 31'h0000_6000 && npsw_mode == 1'b0, "R2 return no branch",
        {npsw_mode, npsw_addr}, 32'h0000_6000);
    chk(rf_we && rf_wdata[31] == 1'b0, "R7 insert zero", {rf_we, 30'd0, rf_wdata[31]}, 32'h8000_0000);
  endtask

  task automatic t_idle();
    @(negedge clk);
    chk(!out_valid && !rf_we && !trace_evt, "R10 idle quiet", {29'd0, out_valid, rf_we, trace_evt}, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h0101_0101 * i;
    regs[5] = 32'hC0DE_F00D;
    regs[6] = 32'h7F56_789A;
    regs[7] = 32'h8765_4321;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_call_nobranch();
    t_idle();
    t_call_r0_link();
    t_call_branch31();
    t_call_branch24();
    t_call_same_reg();
    t_ret_basic();
    t_ret_zero_a();
    t_ret_nobranch();
    t_idle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule